// File: doc/BRIEF.md
# Thread Synchronization Bit Memories

This block holds two shared bit arrays: a 256-bit semaphore array and a 64-bit run-state array. The low 24 bits of the run array show whether each of the 24 hardware threads is running; the upper 40 bits are general-purpose handshake flags shared by the host and the threads. Threads issue one command per cycle: take or drop a semaphore, start a thread, resume a thread, clear a run bit, or stop themselves. Each command carries a register operand and an immediate, which are added and then XOR-folded into a bit index. Each command returns the bit's value from before its own update, so the issuing thread can branch on it.

When a start or resume sets a run bit that was clear and that bit names a thread, the block issues a thread-start request. A start request carries program address zero. A resume request carries the thread's saved program address, taken from a small per-thread address file. A stop clears the issuing thread's run bit and can also write a new saved address for that thread. A separate pipeline read port reads the address file.

The host port sets or clears any single bit of either array and gets back the bit's prior value. Every returned value and every start request is registered and appears one cycle after the command strobe.

Top module: `thread_sync_mem`

## Requirements
- R1: After synchronous reset, every bit of both arrays and every saved address is zero, and cmd_prior, host_prior, start_valid and run_mask are all zero.
- R2: Op code 0 (take) computes s = reg[15:0] + imm[15:0] modulo 2^16 and uses index s[15:8] XOR s[7:0]. It sets that semaphore bit, and cmd_prior shows the bit's old value one cycle later.
- R3: Op code 1 (drop) uses the same index as R2, clears that semaphore bit, and reports the old value on cmd_prior one cycle later.
- R4: Op codes 2, 3 and 4 compute a run index as follows: s = reg[13:0] + imm[5:0] modulo 2^14, and the index is s[13:8] XOR s[5:0]. Op code 4 clears that run bit, reports its old value, and never raises start_valid.
- R5: Op code 2 (start), on a clear run bit whose index is below 24, sets the bit and raises start_valid one cycle later, with start_thread equal to the index and start_pc equal to zero.
- R6: Op code 3 (resume), under the same condition as R5, raises start_valid with start_pc equal to the saved address of the indexed thread.
- R7: Op code 2 or 3 on a run bit that is already set changes nothing, reports 1, and gives no start request.
- R8: Op code 2 or 3 on a clear run bit whose index is 24 or more sets the bit and gives no start request.
- R9: Op code 5 (stop) clears run bit cmd_thread and reports its old value. When cmd_has_target is 1, it also writes cmd_target as the saved address of cmd_thread; when cmd_has_target is 0, the saved address is kept. pc_rd_data always shows the saved address of pc_rd_thread.
- R10: A host command with host_sel = 0 addresses the semaphore array at host_idx, and with host_sel = 1 addresses the run array at host_idx[5:0]. It writes host_val to the bit and returns the bit's prior value on host_prior one cycle later.
- R11: When a thread command and a host command hit the same bit in one cycle, the thread update applies first. The host sees the value after the thread update, and the host's write is the final state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Thread command strobe |
| cmd_op | input | 3 | Thread op code (0 take, 1 drop, 2 start, 3 resume, 4 clear run, 5 stop) |
| cmd_thread | input | 5 | Issuing thread number |
| cmd_reg | input | 32 | Register operand |
| cmd_imm | input | 16 | Immediate operand |
| cmd_has_target | input | 1 | Stop carries a new saved address |
| cmd_target | input | 12 | New saved address for stop |
| host_valid | input | 1 | Host command strobe |
| host_sel | input | 1 | 0 semaphore array, 1 run array |
| host_val | input | 1 | Value written by the host |
| host_idx | input | 8 | Host bit index |
| pc_rd_thread | input | 5 | Address file read select |
| pc_rd_data | output | 12 | Saved address of pc_rd_thread |
| cmd_prior | output | 1 | Prior bit value of the last thread command |
| host_prior | output | 1 | Prior bit value of the last host command |
| start_valid | output | 1 | Thread-start request |
| start_thread | output | 5 | Thread to start |
| start_pc | output | 12 | Start address |
| run_mask | output | 24 | Thread run bits |

## Verification
The bound checker watches every cycle for the following: a start request always names a thread below 24 whose reported prior run bit was 0 and whose run bit is now set. A clear-run or stop command leaves the addressed thread bit cleared. A start or resume on a running thread never produces a request. The arithmetic of the folded indices, the saved-address path through stop and resume, and the ordering when host and thread commands collide can be seen only in the bench. The bench runs directed cases for these and a long random mix compared against a bit-level model.

// File: rtl/sync_mem_pkg.sv
package sync_mem_pkg;

    localparam int ATOM_BITS  = 256;
    localparam int RUN_BITS   = 64;
    localparam int ATOM_IDX_W = $clog2(ATOM_BITS);
    localparam int RUN_IDX_W  = $clog2(RUN_BITS);

    typedef enum logic [2:0] {
        SC_TAKE    = 3'd0,
        SC_DROP    = 3'd1,
        SC_START   = 3'd2,
        SC_RESUME  = 3'd3,
        SC_CLR_RUN = 3'd4,
        SC_STOP    = 3'd5
    } sync_cmd_e;

    typedef struct packed {
        logic                  atom_en;
        logic                  atom_val;
        logic [ATOM_IDX_W-1:0] atom_idx;
        logic                  run_en;
        logic                  run_val;
        logic [RUN_IDX_W-1:0]  run_idx;
        logic                  want_start;
        logic                  from_saved;
        logic                  pc_wr;
    } sync_decode_t;

    // semaphore index: 16-bit sum folded to 8 bits
    function automatic logic [ATOM_IDX_W-1:0] fold_atomic(input logic [31:0] r,
                                                           input logic [15:0] imm);
        logic [15:0] s;
        s = r[15:0] + imm;
        return s[15:8] ^ s[7:0];
    endfunction

    // run index: 14-bit sum folded to 6 bits
    function automatic logic [RUN_IDX_W-1:0] fold_run(input logic [31:0] r,
                                                       input logic [15:0] imm);
        logic [13:0] s;
        s = r[13:0] + {8'd0, imm[5:0]};
        return s[13:8] ^ s[5:0];
    endfunction

endpackage

// File: rtl/sync_cmd_decode.sv
module sync_cmd_decode
    import sync_mem_pkg::*;
#(
    parameter int N_THREADS = 24,
    localparam int TID_W = $clog2(N_THREADS)
) (
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [TID_W-1:0] cmd_thread,
    input  logic [31:0]      cmd_reg,
    input  logic [15:0]      cmd_imm,
    input  logic             cmd_has_target,
    output sync_decode_t     dec
);

    logic [ATOM_IDX_W-1:0] a_idx;
    logic [RUN_IDX_W-1:0]  r_idx;

    assign a_idx = fold_atomic(cmd_reg, cmd_imm);
    assign r_idx = fold_run(cmd_reg, cmd_imm);

    always_comb begin
        dec          = '0;
        dec.atom_idx = a_idx;
        dec.run_idx  = r_idx;
        if (cmd_valid) begin
            case (sync_cmd_e'(cmd_op))
                SC_TAKE: begin
                    dec.atom_en  = 1'b1;
                    dec.atom_val = 1'b1;
                end
                SC_DROP: begin
                    dec.atom_en  = 1'b1;
                    dec.atom_val = 1'b0;
                end
                SC_START, SC_RESUME: begin
                    dec.run_en     = 1'b1;
                    dec.run_val    = 1'b1;
                    dec.want_start = 1'b1;
                    dec.from_saved = (sync_cmd_e'(cmd_op) == SC_RESUME);
                end
                SC_CLR_RUN: begin
                    dec.run_en  = 1'b1;
                    dec.run_val = 1'b0;
                end
                SC_STOP: begin
                    dec.run_en  = 1'b1;
                    dec.run_val = 1'b0;
                    dec.run_idx = RUN_IDX_W'(cmd_thread);
                    dec.pc_wr   = cmd_has_target;
                end
                default: dec = dec;
            endcase
        end
    end

endmodule

// File: rtl/sync_bit_bank.sv
module sync_bit_bank #(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             t_en,
    input  logic             t_val,
    input  logic [IDX_W-1:0] t_idx,
    input  logic             h_en,
    input  logic             h_val,
    input  logic [IDX_W-1:0] h_idx,
    output logic             t_prior,
    output logic             h_prior,
    output logic [DEPTH-1:0] bits
);

    logic [DEPTH-1:0] after_t;
    logic [DEPTH-1:0] after_h;

    // thread update first, host update on top of it
    always_comb begin
        after_t = bits;
        if (t_en) after_t[t_idx] = t_val;
        after_h = after_t;
        if (h_en) after_h[h_idx] = h_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits    <= '0;
            t_prior <= 1'b0;
            h_prior <= 1'b0;
        end else begin
            bits <= after_h;
            if (t_en) t_prior <= bits[t_idx];
            if (h_en) h_prior <= after_t[h_idx];
        end
    end

endmodule

// File: rtl/sync_pc_file.sv
module sync_pc_file #(
    parameter int N_THREADS = 24,
    parameter int PC_W      = 12,
    localparam int TID_W = $clog2(N_THREADS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [TID_W-1:0] wa,
    input  logic [PC_W-1:0]  wd,
    input  logic [TID_W-1:0] ra_a,
    output logic [PC_W-1:0]  rd_a,
    input  logic [TID_W-1:0] ra_b,
    output logic [PC_W-1:0]  rd_b
);

    logic [PC_W-1:0] saved [N_THREADS];

    for (genvar g = 0; g < N_THREADS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                saved[g] <= '0;
            else if (we && wa == TID_W'(g))         saved[g] <= wd;
        end
    end

    always_comb begin
        rd_a = '0;
        rd_b = '0;
        if (int'(ra_a) < N_THREADS) rd_a = saved[ra_a];
        if (int'(ra_b) < N_THREADS) rd_b = saved[ra_b];
    end

endmodule

// File: rtl/thread_sync_mem.sv
module thread_sync_mem
    import sync_mem_pkg::*;
#(
    parameter int N_THREADS = 24,
    parameter int PC_W      = 12,
    localparam int TID_W = $clog2(N_THREADS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [TID_W-1:0]     cmd_thread,
    input  logic [31:0]          cmd_reg,
    input  logic [15:0]          cmd_imm,
    input  logic                 cmd_has_target,
    input  logic [PC_W-1:0]      cmd_target,
    input  logic                 host_valid,
    input  logic                 host_sel,
    input  logic                 host_val,
    input  logic [ATOM_IDX_W-1:0] host_idx,
    input  logic [TID_W-1:0]     pc_rd_thread,
    output logic [PC_W-1:0]      pc_rd_data,
    output logic                 cmd_prior,
    output logic                 host_prior,
    output logic                 start_valid,
    output logic [TID_W-1:0]     start_thread,
    output logic [PC_W-1:0]      start_pc,
    output logic [N_THREADS-1:0] run_mask
);

    sync_decode_t          dec;
    logic [ATOM_BITS-1:0]  atom_bits;
    logic [RUN_BITS-1:0]   run_bits;
    logic                  atom_t_prior, atom_h_prior;
    logic                  run_t_prior, run_h_prior;
    logic [PC_W-1:0]       saved_pc;
    logic                  start_now;
    logic                  cmd_atom_q;
    logic                  host_sel_q;

    sync_cmd_decode #(.N_THREADS(N_THREADS)) u_dec (
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .cmd_thread     (cmd_thread),
        .cmd_reg        (cmd_reg),
        .cmd_imm        (cmd_imm),
        .cmd_has_target (cmd_has_target),
        .dec            (dec)
    );

    sync_bit_bank #(.DEPTH(ATOM_BITS)) u_atom (
        .clk     (clk),
        .rst     (rst),
        .t_en    (dec.atom_en),
        .t_val   (dec.atom_val),
        .t_idx   (dec.atom_idx),
        .h_en    (host_valid && !host_sel),
        .h_val   (host_val),
        .h_idx   (host_idx),
        .t_prior (atom_t_prior),
        .h_prior (atom_h_prior),
        .bits    (atom_bits)
    );

    sync_bit_bank #(.DEPTH(RUN_BITS)) u_run (
        .clk     (clk),
        .rst     (rst),
        .t_en    (dec.run_en),
        .t_val   (dec.run_val),
        .t_idx   (dec.run_idx),
        .h_en    (host_valid && host_sel),
        .h_val   (host_val),
        .h_idx   (host_idx[RUN_IDX_W-1:0]),
        .t_prior (run_t_prior),
        .h_prior (run_h_prior),
        .bits    (run_bits)
    );

    sync_pc_file #(.N_THREADS(N_THREADS), .PC_W(PC_W)) u_pc (
        .clk  (clk),
        .rst  (rst),
        .we   (dec.pc_wr),
        .wa   (cmd_thread),
        .wd   (cmd_target),
        .ra_a (dec.run_idx[TID_W-1:0]),
        .rd_a (saved_pc),
        .ra_b (pc_rd_thread),
        .rd_b (pc_rd_data)
    );

    // start only on a clear run bit that names a real thread
    assign start_now = dec.want_start && !run_bits[dec.run_idx]
                       && (int'(dec.run_idx) < N_THREADS);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_valid  <= 1'b0;
            start_thread <= '0;
            start_pc     <= '0;
            cmd_atom_q   <= 1'b0;
            host_sel_q   <= 1'b0;
        end else begin
            start_valid <= start_now;
            if (start_now) begin
                start_thread <= dec.run_idx[TID_W-1:0];
                start_pc     <= dec.from_saved ? saved_pc : '0;
            end
            if (cmd_valid)  cmd_atom_q <= dec.atom_en;
            if (host_valid) host_sel_q <= host_sel;
        end
    end

    assign cmd_prior  = cmd_atom_q ? atom_t_prior : run_t_prior;
    assign host_prior = host_sel_q ? run_h_prior  : atom_h_prior;
    assign run_mask   = run_bits[N_THREADS-1:0];

endmodule

// File: rtl/sync_mem_chk.sv
module sync_mem_chk
    import sync_mem_pkg::*;
#(
    parameter int N_THREADS = 24,
    localparam int TID_W = $clog2(N_THREADS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid,
    input logic [2:0]           cmd_op,
    input logic [TID_W-1:0]     cmd_thread,
    input logic [31:0]          cmd_reg,
    input logic [15:0]          cmd_imm,
    input logic                 host_valid,
    input logic                 start_valid,
    input logic [TID_W-1:0]     start_thread,
    input logic                 cmd_prior,
    input logic [N_THREADS-1:0] run_mask
);

    logic [RUN_IDX_W-1:0] rix;
    assign rix = fold_run(cmd_reg, cmd_imm);

    // R5
    start_prior_chk: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> !cmd_prior);

    // R8
    start_range_chk: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> (int'(start_thread) < N_THREADS));

    // R5
    start_run_chk: assert property (@(posedge clk) disable iff (rst)
        (start_valid && !$past(host_valid)) |-> run_mask[start_thread]);

    // R4
    clr_run_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'(SC_CLR_RUN) && !host_valid && int'(rix) < N_THREADS)
        |=> !run_mask[$past(rix[TID_W-1:0])]);

    // R9
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'(SC_STOP) && !host_valid && int'(cmd_thread) < N_THREADS)
        |=> !run_mask[$past(cmd_thread)]);

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == 3'(SC_START) || cmd_op == 3'(SC_RESUME))
         && int'(rix) < N_THREADS && run_mask[rix[TID_W-1:0]])
        |=> !start_valid);

endmodule

bind thread_sync_mem sync_mem_chk #(.N_THREADS(N_THREADS)) u_chk (.*);

// File: tb/sim_thread_sync_mem.sv
module sim_thread_sync_mem;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 0;
    logic [2:0]  cmd_op = 0;
    logic [4:0]  cmd_thread = 0;
    logic [31:0] cmd_reg = 0;
    logic [15:0] cmd_imm = 0;
    logic        cmd_has_target = 0;
    logic [11:0] cmd_target = 0;
    logic        host_valid = 0;
    logic        host_sel = 0;
    logic        host_val = 0;
    logic [7:0]  host_idx = 0;
    logic [4:0]  pc_rd_thread = 0;
    logic [11:0] pc_rd_data;
    logic        cmd_prior, host_prior, start_valid;
    logic [4:0]  start_thread;
    logic [11:0] start_pc;
    logic [23:0] run_mask;

    int checks = 0;
    int fails  = 0;

    logic [255:0] m_atom = '0;
    logic [63:0]  m_run  = '0;
    logic [11:0]  m_pc [24];

    always #5 clk = ~clk;

    thread_sync_mem u0 (.*);

    function automatic logic [7:0] ref_aidx(logic [31:0] r, logic [15:0] i);
        logic [15:0] s = r[15:0] + i;
        return s[15:8] ^ s[7:0];
    endfunction

    function automatic logic [5:0] ref_ridx(logic [31:0] r, logic [15:0] i);
        logic [13:0] s = r[13:0] + {8'd0, i[5:0]};
        return s[13:8] ^ s[5:0];
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic cv, logic [2:0] op, logic [4:0] th,
                        logic [31:0] rg, logic [15:0] im, logic ht, logic [11:0] tg,
                        logic hv, logic hs, logic hval, logic [7:0] hi);
        logic ecp = 0, ehp = 0, esv = 0;
        logic [4:0] eth = 0;
        logic [11:0] epc = 0;
        logic [7:0] ai;
        logic [5:0] ri;
        cmd_valid = cv; cmd_op = op; cmd_thread = th; cmd_reg = rg; cmd_imm = im;
        cmd_has_target = ht; cmd_target = tg;
        host_valid = hv; host_sel = hs; host_val = hval; host_idx = hi;
        pc_rd_thread = th;
        ai = ref_aidx(rg, im);
        ri = ref_ridx(rg, im);
        if (cv) begin
            case (op)
                3'd0: begin ecp = m_atom[ai]; m_atom[ai] = 1'b1; end
                3'd1: begin ecp = m_atom[ai]; m_atom[ai] = 1'b0; end
                3'd2, 3'd3: begin
                    ecp = m_run[ri];
                    if (!m_run[ri]) begin
                        m_run[ri] = 1'b1;
                        if (ri < 24) begin
                            esv = 1; eth = ri[4:0];
                            epc = (op == 3'd2) ? 12'd0 : m_pc[ri[4:0]];
                        end
                    end
                end
                3'd4: begin ecp = m_run[ri]; m_run[ri] = 1'b0; end
                3'd5: begin
                    ecp = m_run[th]; m_run[th] = 1'b0;
                    if (ht) m_pc[th] = tg;
                end
                default: ;
            endcase
        end
        if (hv) begin
            if (hs) begin ehp = m_run[hi[5:0]]; m_run[hi[5:0]] = hval; end
            else    begin ehp = m_atom[hi];     m_atom[hi]     = hval; end
        end
        @(negedge clk);
        cmd_valid = 0; host_valid = 0;
        if (cv && op <= 3'd5) chk(tag, "cmd_prior", 32'(cmd_prior), 32'(ecp));
        if (hv) chk(tag, "host_prior", 32'(host_prior), 32'(ehp));
        chk(tag, "start_valid", 32'(start_valid), 32'(esv));
        if (esv) begin
            chk(tag, "start_thread", 32'(start_thread), 32'(eth));
            chk(tag, "start_pc", 32'(start_pc), 32'(epc));
        end
        chk(tag, "run_mask", 32'(run_mask), 32'(m_run[23:0]));
        chk(tag, "pc_rd_data", 32'(pc_rd_data), 32'(m_pc[th]));
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        for (int i = 0; i < 24; i++) m_pc[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "cmd_prior", 32'(cmd_prior), 0);
        chk("R1", "host_prior", 32'(host_prior), 0);
        chk("R1", "start_valid", 32'(start_valid), 0);
        chk("R1", "run_mask", 32'(run_mask), 0);
        chk("R1", "pc_rd_data", 32'(pc_rd_data), 0);
        // R2 take, index 0x12^0x44
        step("R2", 1, 3'd0, 0, 32'h1234, 16'h0010, 0, 0, 0, 0, 0, 0);
        step("R2", 1, 3'd0, 0, 32'h1234, 16'h0010, 0, 0, 0, 0, 0, 0);
        // R3 drop
        step("R3", 1, 3'd1, 0, 32'h1200, 16'h0044, 0, 0, 0, 0, 0, 0);
        step("R3", 1, 3'd1, 0, 32'h1234, 16'h0010, 0, 0, 0, 0, 0, 0);
        // R5 start thread 5
        step("R5", 1, 3'd2, 0, 32'd5, 16'd0, 0, 0, 0, 0, 0, 0);
        // R7 already running
        step("R7", 1, 3'd2, 0, 32'd5, 16'd0, 0, 0, 0, 0, 0, 0);
        step("R7", 1, 3'd3, 0, 32'd3, 16'd2, 0, 0, 0, 0, 0, 0);
        // R9 stop with target
        step("R9", 1, 3'd5, 5'd5, 0, 0, 1, 12'h0AB, 0, 0, 0, 0);
        // R6 resume thread 5 at saved address
        step("R6", 1, 3'd3, 5'd5, 32'd5, 16'd0, 0, 0, 0, 0, 0, 0);
        // R9 stop without target keeps address
        step("R9", 1, 3'd5, 5'd5, 0, 0, 0, 12'h777, 0, 0, 0, 0);
        // R4 carry into fold: 0x100 + 3 -> index 2
        step("R4", 1, 3'd2, 5'd2, 32'h100, 16'd3, 0, 0, 0, 0, 0, 0);
        // R8 flag bit 40
        step("R8", 1, 3'd2, 0, 32'd40, 16'd0, 0, 0, 0, 0, 0, 0);
        step("R8", 0, 3'd0, 0, 0, 0, 0, 0, 1, 1, 1, 8'd40);
        // R4 clear run
        step("R4", 1, 3'd4, 0, 32'd38, 16'd2, 0, 0, 0, 0, 0, 0);
        step("R4", 0, 3'd0, 0, 0, 0, 0, 0, 1, 1, 0, 8'd40);
        // R10 host on semaphore array
        step("R10", 0, 3'd0, 0, 0, 0, 0, 0, 1, 0, 1, 8'd200);
        step("R10", 0, 3'd0, 0, 0, 0, 0, 0, 1, 0, 0, 8'd200);
        // R11 collisions
        step("R11", 1, 3'd0, 0, 32'h0, 16'h0077, 0, 0, 1, 0, 0, 8'h77);
        step("R11", 1, 3'd0, 0, 32'h0, 16'h0077, 0, 0, 0, 0, 0, 0);
        step("R11", 1, 3'd2, 0, 32'd7, 16'd0, 0, 0, 1, 1, 0, 8'd7);
        step("R11", 1, 3'd2, 0, 32'd7, 16'd0, 0, 0, 0, 0, 0, 0);
        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [2:0] op = 3'($urandom_range(0, 5));
            logic [31:0] rg = (($urandom & 1) != 0) ? 32'($urandom_range(0, 70)) : $urandom;
            logic [15:0] im = 16'($urandom);
            string tg;
            case (op)
                3'd0: tg = "R2";
                3'd1: tg = "R3";
                3'd2: tg = "R5";
                3'd3: tg = "R6";
                3'd4: tg = "R4";
                default: tg = "R9";
            endcase
            if (op == 3'd0 || op == 3'd1) rg = rg & 32'h0000_0F0F;
            step(tg, 1'($urandom_range(0, 3) != 0), op, 5'($urandom_range(0, 23)), rg, im,
                 1'($urandom), 12'($urandom), 1'($urandom_range(0, 2) == 0), 1'($urandom),
                 1'($urandom), 8'($urandom_range(0, 63)));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule